// File: doc/BRIEF.md
# Boot-Remappable System Address Decoder

This block sits between a 32-bit system bus and its slaves, and turns each access address into a slave selection. The top four address bits pick one of sixteen 256 MB banks. Bank 0 holds the internal memories, which a second decode divides further. Banks 1 to 8 go to the external memory interface. Bank 15 goes to the peripheral bridge. Any address that maps to nothing raises an abort toward the requesting master.

The lowest 1 MB window, at address zero, is an alias. At power-up it shows either the boot ROM or external chip select 0, depending on a boot-mode pin. After software issues a one-shot remap command, the window shows the fast SRAM instead, and it keeps doing so until the next reset. The fast SRAM can also always be reached at its fixed home address. The selects and the abort are combinational from the address, the valid strobe, the boot pin and the registered remap flag.

Top module: `sys_addr_decoder`

## Requirements
- R1: An access with address bits [31:28] equal to 15 asserts only the peripheral-bridge select, `slv_sel` bit 4, with no chip select and no abort.
- R2: Banks 1 to 6 assert the external-interface select (`slv_sel` bit 3) and exactly chip select `ext_cs[bank-1]`, with no abort.
- R3: Banks 7 and 8 assert the external-interface select with no chip select, and they assert `abort`.
- R4: Banks 9 to 14 assert `abort` and no slave select or chip select.
- R5: In bank 0 the 1 MB region index is address bits [27:20]. Region 1 selects the tightly coupled SRAM (`slv_sel` bit 1). Region 3 selects the fast SRAM (`slv_sel` bit 2) whatever the remap state. Region 4 selects the boot ROM (`slv_sel` bit 0). Region 2 and regions 5 to 255 assert `abort` only.
- R6: Before remap, region 0 of bank 0 selects the boot ROM when `boot_sel` is 1. When `boot_sel` is 0 it selects the external interface with `ext_cs[0]`.
- R7: A one-cycle `remap_cmd` pulse sets the remap flag at the next rising clock edge. From then on, region 0 selects the fast SRAM whatever `boot_sel` is. The flag holds without further pulses and is cleared only by a synchronous reset (`rst_n` low).
- R8: While `acc_valid` is 0, `slv_sel`, `ext_cs` and `abort` are all 0.
- R9: At most one `slv_sel` bit is set in any cycle, at most one `ext_cs` bit is set, and a chip select is never active together with `abort`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the remap flag |
| rst_n | input | 1 | Synchronous active-low reset; clears the remap flag |
| bus_addr | input | 32 | Access address |
| acc_valid | input | 1 | Access strobe; the outputs are meaningful only while it is 1 |
| boot_sel | input | 1 | Boot-mode pin: 1 = ROM at zero, 0 = external chip select 0 at zero |
| remap_cmd | input | 1 | One-cycle pulse that moves the fast SRAM into the zero window |
| slv_sel | output | 5 | One-hot slave select: bit0 ROM, bit1 TCM, bit2 fast SRAM, bit3 external interface, bit4 peripheral bridge |
| ext_cs | output | 6 | External chip selects 0 to 5 |
| abort | output | 1 | Error response for an unmapped bank or region |

## Verification
The embedded assertions watch, on every cycle, the properties that involve nothing but the outputs: a single active slave select, a single chip select, no chip select during an abort, and silent outputs while the strobe is low. They also check that the remap flag is set by a pulse, stays set, and drives the zero window to the SRAM. Whether each bank and region lands on the right slave can only be shown by the bench's sweeps. These cover every bank at several offsets and every bank-0 region, under both boot-pin values, before and after remap, and again after a reset clears the remap flag.

// File: rtl/addr_dec_pkg.sv
// Package: shared constants and the slave-select index encoding for the
// system address decoder. Assumes a single bus master view of the map.
package addr_dec_pkg;

    // Index of each bit in the one-hot slave select vector
    typedef enum logic [2:0] {
        SLV_ROM    = 3'd0,
        SLV_TCM    = 3'd1,
        SLV_SRAM   = 3'd2,
        SLV_EXT    = 3'd3,
        SLV_PERIPH = 3'd4
    } slave_idx_e;

    localparam int NUM_SLAVES = 5;

endpackage

// File: rtl/addr_remap_ctrl.sv
// Module: addr_remap_ctrl
// Holds the remap flag. The flag clears on synchronous active-low reset,
// sets on the clock edge that samples a remap command, and then stays set
// until the next reset. Assumes remap_cmd is synchronous to clk.
module addr_remap_ctrl (
    input  logic clk,
    input  logic rst_n,
    input  logic remap_cmd,
    output logic remap_q
);

    // Sticky remap flag: set once per reset epoch
    always_ff @(posedge clk) begin
        if (!rst_n)
            remap_q <= 1'b0;
        else if (remap_cmd)
            remap_q <= 1'b1;
    end

    // R7
    remap_sets_chk: assert property (@(posedge clk) disable iff (!rst_n)
        remap_cmd |=> remap_q);

    // R7
    remap_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        remap_q |=> remap_q);

    // R7
    remap_reset_chk: assert property (@(posedge clk)
        !rst_n |=> !remap_q);

endmodule

// File: rtl/addr_bank_decode.sv
// Module: addr_bank_decode
// First-level decode. Takes the bank field from the top address bits and
// flags the internal bank, the external interface (with chip selects for
// the banks that have one), the peripheral bank, and unmapped banks.
// Assumes EXT_LAST - EXT_FIRST + 1 >= NUM_CS.
module addr_bank_decode #(
    parameter int ADDR_W      = 32,
    parameter int BANK_W      = 4,
    parameter int NUM_CS      = 6,
    parameter int INT_BANK    = 0,
    parameter int EXT_FIRST   = 1,
    parameter int EXT_LAST    = 8,
    parameter int PERIPH_BANK = 15
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] addr,
    input  logic              valid,
    output logic              hit_int,
    output logic              sel_ext,
    output logic              sel_periph,
    output logic [NUM_CS-1:0] cs_vec,
    output logic              bank_abort
);

    localparam int BANK_LSB = ADDR_W - BANK_W;

    logic [BANK_W-1:0] bank;
    logic              in_ext_range;
    logic              cs_any;

    // Extract the bank field
    always_comb bank = addr[ADDR_W-1:BANK_LSB];

    // One chip select per external bank that has one
    for (genvar i = 0; i < NUM_CS; i++) begin : g_cs
        always_comb cs_vec[i] = valid && (bank == BANK_W'(EXT_FIRST + i));
    end

    // Classify the bank into internal, external, peripheral or unmapped
    always_comb begin
        in_ext_range = (bank >= BANK_W'(EXT_FIRST)) && (bank <= BANK_W'(EXT_LAST));
        cs_any       = |cs_vec;
        hit_int      = valid && (bank == BANK_W'(INT_BANK));
        sel_ext      = valid && in_ext_range;
        sel_periph   = valid && (bank == BANK_W'(PERIPH_BANK));
        bank_abort   = valid && !hit_int && !sel_periph && !(sel_ext && cs_any);
    end

    // R2
    cs_needs_ext_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (|cs_vec) |-> sel_ext);

    // R9
    cs_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(cs_vec));

endmodule

// File: rtl/addr_intmem_decode.sv
// Module: addr_intmem_decode
// Second-level decode inside the internal bank. The 1 MB region index picks
// the TCM, the fast SRAM or the ROM. Region 0 is a boot alias that shows the
// ROM or external chip select 0, chosen by the boot pin, until remap, and the
// fast SRAM after remap. Any other region aborts. Assumes hit is already
// qualified by the access strobe.
module addr_intmem_decode #(
    parameter int REGION_W     = 8,
    parameter int ALIAS_REGION = 0,
    parameter int TCM_REGION   = 1,
    parameter int SRAM_REGION  = 3,
    parameter int ROM_REGION   = 4
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                hit,
    input  logic [REGION_W-1:0] region,
    input  logic                boot_sel,
    input  logic                remap,
    output logic                sel_rom,
    output logic                sel_tcm,
    output logic                sel_sram,
    output logic                alias_ext,
    output logic                int_abort
);

    logic in_alias;
    logic in_tcm;
    logic in_sram;
    logic in_rom;

    // Match the region index against the fixed placements
    always_comb begin
        in_alias = hit && (region == REGION_W'(ALIAS_REGION));
        in_tcm   = hit && (region == REGION_W'(TCM_REGION));
        in_sram  = hit && (region == REGION_W'(SRAM_REGION));
        in_rom   = hit && (region == REGION_W'(ROM_REGION));
    end

    // Resolve the alias window and produce the per-memory selects
    always_comb begin
        sel_tcm   = in_tcm;
        sel_sram  = in_sram || (in_alias && remap);
        sel_rom   = in_rom  || (in_alias && !remap && boot_sel);
        alias_ext = in_alias && !remap && !boot_sel;
        int_abort = hit && !(in_alias || in_tcm || in_sram || in_rom);
    end

    // R7
    alias_after_remap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (remap && hit && region == REGION_W'(ALIAS_REGION)) |-> (sel_sram && !sel_rom && !alias_ext));

    // R6
    alias_boot_rom_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!remap && boot_sel && hit && region == REGION_W'(ALIAS_REGION)) |-> (sel_rom && !sel_sram));

    // R5
    int_abort_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        int_abort |-> !(sel_rom || sel_tcm || sel_sram || alias_ext));

endmodule

// File: rtl/sys_addr_decoder.sv
// Module: sys_addr_decoder (top)
// Routes each bus access to one slave and flags unmapped addresses. It
// combines the bank decode, the internal-memory decode and the remap flag.
// The outputs are combinational from the address and the strobe. Assumes a
// single access per cycle, with any arbitration done upstream.
module sys_addr_decoder
    import addr_dec_pkg::*;
#(
    parameter int ADDR_W      = 32,
    parameter int BANK_W      = 4,
    parameter int REGION_LSB  = 20,
    parameter int NUM_CS      = 6,
    parameter int EXT_FIRST   = 1,
    parameter int EXT_LAST    = 8,
    parameter int PERIPH_BANK = 15
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic [ADDR_W-1:0]     bus_addr,
    input  logic                  acc_valid,
    input  logic                  boot_sel,
    input  logic                  remap_cmd,
    output logic [NUM_SLAVES-1:0] slv_sel,
    output logic [NUM_CS-1:0]     ext_cs,
    output logic                  abort
);

    localparam int BANK_LSB = ADDR_W - BANK_W;
    localparam int REGION_W = BANK_LSB - REGION_LSB;

    logic              remap_q;
    logic              hit_int;
    logic              sel_ext;
    logic              sel_periph;
    logic [NUM_CS-1:0] cs_vec;
    logic              bank_abort;
    logic              sel_rom;
    logic              sel_tcm;
    logic              sel_sram;
    logic              alias_ext;
    logic              int_abort;
    logic [REGION_W-1:0] region;

    // Pick the region field for the second-level decode
    always_comb region = bus_addr[BANK_LSB-1:REGION_LSB];

    addr_remap_ctrl u_remap (
        .clk       (clk),
        .rst_n     (rst_n),
        .remap_cmd (remap_cmd),
        .remap_q   (remap_q)
    );

    addr_bank_decode #(
        .ADDR_W      (ADDR_W),
        .BANK_W      (BANK_W),
        .NUM_CS      (NUM_CS),
        .INT_BANK    (0),
        .EXT_FIRST   (EXT_FIRST),
        .EXT_LAST    (EXT_LAST),
        .PERIPH_BANK (PERIPH_BANK)
    ) u_bank (
        .clk        (clk),
        .rst_n      (rst_n),
        .addr       (bus_addr),
        .valid      (acc_valid),
        .hit_int    (hit_int),
        .sel_ext    (sel_ext),
        .sel_periph (sel_periph),
        .cs_vec     (cs_vec),
        .bank_abort (bank_abort)
    );

    addr_intmem_decode #(
        .REGION_W (REGION_W)
    ) u_intmem (
        .clk       (clk),
        .rst_n     (rst_n),
        .hit       (hit_int),
        .region    (region),
        .boot_sel  (boot_sel),
        .remap     (remap_q),
        .sel_rom   (sel_rom),
        .sel_tcm   (sel_tcm),
        .sel_sram  (sel_sram),
        .alias_ext (alias_ext),
        .int_abort (int_abort)
    );

    // Merge both decode levels into the one-hot select vector
    always_comb begin
        slv_sel             = '0;
        slv_sel[SLV_ROM]    = sel_rom;
        slv_sel[SLV_TCM]    = sel_tcm;
        slv_sel[SLV_SRAM]   = sel_sram;
        slv_sel[SLV_EXT]    = sel_ext || alias_ext;
        slv_sel[SLV_PERIPH] = sel_periph;
    end

    // Add chip select 0 for the boot alias, and merge the two abort sources
    always_comb begin
        ext_cs    = cs_vec;
        ext_cs[0] = cs_vec[0] || alias_ext;
        abort     = bank_abort || int_abort;
    end

    // R9
    sel_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(slv_sel));

    // R9
    abort_no_cs_chk: assert property (@(posedge clk) disable iff (!rst_n)
        abort |-> (ext_cs == '0));

    // R8
    idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !acc_valid |-> (slv_sel == '0 && ext_cs == '0 && !abort));

    // R2
    cs_implies_ext_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (|ext_cs) |-> slv_sel[SLV_EXT]);

endmodule

// File: tb/sys_addr_decoder_tb.sv
// Bench: sweeps every bank at several offsets and every bank-0 region under
// each boot and remap state, and compares against an arithmetic model.
module sys_addr_decoder_tb_top;

    logic        clk;
    logic        rst_n;
    logic [31:0] bus_addr;
    logic        acc_valid;
    logic        boot_sel;
    logic        remap_cmd;
    logic [4:0]  slv_sel;
    logic [5:0]  ext_cs;
    logic        abort;

    int n_vec;
    int n_bad;
    bit done;

    sys_addr_decoder dut_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .bus_addr  (bus_addr),
        .acc_valid (acc_valid),
        .boot_sel  (boot_sel),
        .remap_cmd (remap_cmd),
        .slv_sel   (slv_sel),
        .ext_cs    (ext_cs),
        .abort     (abort)
    );

    initial clk = 1'b0;
    always #4 clk = ~clk;

    // Expected {abort, ext_cs[5:0], slv_sel[4:0]} from the requirements
    function automatic logic [11:0] model(input logic [31:0] a, input logic v,
                                          input logic boot, input logic rm);
        logic [4:0] s;
        logic [5:0] c;
        logic       ab;
        int         bk;
        int         rg;
        s = '0; c = '0; ab = 1'b0;
        bk = int'(a[31:28]);
        rg = int'(a[27:20]);
        if (v) begin
            if (bk == 15)                  s[4] = 1'b1;
            else if (bk >= 1 && bk <= 6) begin s[3] = 1'b1; c[bk-1] = 1'b1; end
            else if (bk == 7 || bk == 8) begin s[3] = 1'b1; ab = 1'b1; end
            else if (bk != 0)              ab = 1'b1;
            else if (rg == 1)              s[1] = 1'b1;
            else if (rg == 3)              s[2] = 1'b1;
            else if (rg == 4)              s[0] = 1'b1;
            else if (rg == 0) begin
                if (rm)        s[2] = 1'b1;
                else if (boot) s[0] = 1'b1;
                else begin s[3] = 1'b1; c[0] = 1'b1; end
            end
            else ab = 1'b1;
        end
        return {ab, c, s};
    endfunction

    // Apply one vector, let it settle, compare
    task automatic apply(input logic [31:0] a, input logic v, input logic rm,
                         input string req);
        logic [11:0] exp;
        @(negedge clk);
        bus_addr  = a;
        acc_valid = v;
        #2;
        exp = model(a, v, boot_sel, rm);
        n_vec++;
        if ({abort, ext_cs, slv_sel} !== exp) begin
            n_bad++;
            $display("FAIL %s addr=%h valid=%0b boot=%0b: got %b expected %b",
                     req, a, v, boot_sel, {abort, ext_cs, slv_sel}, exp);
        end
    endtask

    // Sweep all banks at several offsets, and all bank-0 regions
    task automatic sweep(input logic rm);
        logic [27:0] offs [4];
        offs[0] = 28'h0000000; offs[1] = 28'hFFFFFFF;
        offs[2] = 28'h0123456; offs[3] = 28'h8000000;
        for (int b = 1; b < 16; b++) begin
            for (int o = 0; o < 4; o++) begin
                string rq;
                rq = (b == 15) ? "R1" : (b <= 6) ? "R2" : (b <= 8) ? "R3" : "R4";
                apply({4'(b), offs[o]}, 1'b1, rm, rq);
            end
        end
        for (int r = 0; r < 256; r++) begin
            apply({4'h0, 8'(r), 20'h00000}, 1'b1, rm, (r == 0) ? (rm ? "R7" : "R6") : "R5");
            apply({4'h0, 8'(r), 20'hFFFFF}, 1'b1, rm, (r == 0) ? (rm ? "R7" : "R6") : "R5");
        end
        // R8: strobe low over a spread of addresses
        for (int b = 0; b < 16; b++)
            apply({4'(b), 8'h00, 20'h00040}, 1'b0, rm, "R8");
    endtask

    initial begin
        n_vec = 0; n_bad = 0; done = 1'b0;
        rst_n = 1'b0; bus_addr = '0; acc_valid = 1'b0;
        boot_sel = 1'b1; remap_cmd = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        apply(32'h0, 1'b0, 1'b0, "R8");     // reset state: quiet outputs
        apply(32'h0, 1'b1, 1'b0, "R6");     // reset leaves remap clear

        boot_sel = 1'b1; sweep(1'b0);
        boot_sel = 1'b0; sweep(1'b0);

        // R7: one-cycle remap pulse
        @(negedge clk); remap_cmd = 1'b1;
        @(negedge clk); remap_cmd = 1'b0;
        repeat (5) @(negedge clk);
        boot_sel = 1'b0; sweep(1'b1);
        boot_sel = 1'b1; sweep(1'b1);

        // R7: reset clears remap, zero window returns to boot choice
        @(negedge clk); rst_n = 1'b0;
        @(negedge clk); rst_n = 1'b1;
        boot_sel = 1'b0;
        apply(32'h0000_1000, 1'b1, 1'b0, "R7");
        boot_sel = 1'b1;
        apply(32'h0000_1000, 1'b1, 1'b0, "R7");
        apply(32'h0030_0000, 1'b1, 1'b0, "R5");
        done = 1'b1;
    end

    // Watchdog and summary
    initial begin
        for (int t = 0; t < 150000; t++) begin
            @(posedge clk);
            if (done) break;
        end
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog: got timeout expected completion");
        end
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

endmodule